// File: doc/BRIEF.md
# Read-Only I2C Status Slave

This block is an I2C-bus target that answers only read requests. When it is read, it returns one status byte. The byte holds a sticky power-on flag, a loop-lock indication and a 3-bit level code. The level code is derived from four thermometer-coded comparator inputs. The block sends the byte again each time the master acknowledges. It stops driving the bus as soon as the master withholds its acknowledge.

SCL and SDA arrive asynchronously. They are synchronised into the system clock domain and filtered with two agreeing samples. START and STOP are recognised from SDA edges while SCL is high. SDA is open-drain: the block never drives it high. It only asserts `sda_oe` to pull the line low, and it changes that output only while SCL is low. Two select inputs supply the variable low bits of the 7-bit address, so several of these slaves can share one bus.

Top module: `i2c_status_slave`

## Requirements
- R1: The block acknowledges an address byte only when all three conditions hold: its upper five bits are 1,1,0,0,0, the next two equal `addr_sel[1:0]`, and the final R/W bit is 1. It acknowledges by asserting `sda_oe` for the whole ninth clock.
- R2: A non-matching address or a write request receives no acknowledge. After it, `sda_oe` stays low until the next START, so a master clocking on reads 0xFF.
- R3: The status byte is sent MSB first. Its layout is bit7 = power-on flag, bit6 = lock, bits 5..3 = 0, bits 2..0 = level code.
- R4: The level code is the number of asserted `cmp_i` bits. Levels 0 to 4 are sent as 000 to 100. The level code and the lock bit are captured together when each status byte is loaded, at the SCL fall that ends the preceding acknowledge.
- R5: When the master drives SDA low on the ninth clock after a status byte, the block sends a freshly captured status byte.
- R6: When the master leaves SDA high on the ninth clock, the block releases SDA and ignores further clocks until a START.
- R7: The power-on flag is 1 after reset and is set again while `supply_fail_i` is asserted. It clears only when a read ends with a master NACK. A STOP after a master ACK leaves it set.
- R8: `sda_oe` rises only while SCL is low.
- R9: A repeated START at any point restarts address reception.
- R10: A STOP returns the block to idle with SDA released, and a following read works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Variable address bits (bits 2..1 of the address byte) |
| lock_i | input | 1 | Loop-lock indication |
| supply_fail_i | input | 1 | Power-fail indication, sets the power-on flag |
| cmp_i | input | 4 | Thermometer-coded level comparators |

## Verification
The bench sweeps every combination of select inputs, address bits and R/W. A decoder that ignored R/W or the select bits would acknowledge writes or a neighbour's address, and the bench then reads a non-0xFF byte where it expects a released line. The bench steps the comparators through all five levels with both lock values, and changes them in the middle of a byte. A design that latched the level only once per transfer would repeat a stale second byte. The power-on flag is checked across a NACK-ended read, an ACK followed by STOP, and a supply-fail pulse. A design that cleared the flag on any STOP would lose it in the second of these cases. Repeated STARTs after a foreign address and after a partial address must still lead to an acknowledge.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int CMP_W = 4;
    localparam int LVL_W = $clog2(CMP_W + 1);
    localparam int PAD_W = 8 - 2 - LVL_W;
    localparam logic [4:0] DEV_PREFIX = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ADDR_ACK,
        ST_TX,
        ST_HOST_ACK,
        ST_RELOAD
    } ctl_state_e;

    typedef struct packed {
        logic             por;
        logic             lock;
        logic [PAD_W-1:0] pad;
        logic [LVL_W-1:0] level;
    } status_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic [LVL_W-1:0] therm_level(input logic [CMP_W-1:0] t);
        logic [LVL_W-1:0] n;
        n = '0;
        for (int i = 0; i < CMP_W; i++)
            n = n + {{(LVL_W-1){1'b0}}, t[i]};
        return n;
    endfunction

    function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] sel);
        return (b[7:3] == DEV_PREFIX) && (b[2:1] == sel) && b[0];
    endfunction

endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/stat_glitch_filter.sv
module stat_glitch_filter #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic hold_b;
        logic lvl_b;
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_b <= RST_VAL[g];
                lvl_b  <= RST_VAL[g];
            end else begin
                hold_b <= d[g];
                if (d[g] == hold_b) lvl_b <= hold_b;
            end
        end
        assign q[g] = lvl_b;
    end
endmodule

// File: rtl/stat_bus_events.sv
module stat_bus_events
    import i2c_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    always_comb begin
        evt.start = scl & scl_d & sda_d & ~sda;
        evt.stop  = scl & scl_d & ~sda_d & sda;
        evt.rise  = scl & ~scl_d;
        evt.fall  = ~scl & scl_d;
        evt.sda   = sda;
    end
endmodule

// File: rtl/stat_por_flag.sv
module stat_por_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic por_o
);
    always_ff @(posedge clk) begin
        if (rst || set_i) por_o <= 1'b1;
        else if (clr_i)   por_o <= 1'b0;
    end
endmodule

// File: rtl/stat_slave_ctrl.sv
module stat_slave_ctrl
    import i2c_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [1:0] addr_sel,
    input  status_t    snapshot,
    output logic       sda_oe,
    output logic       por_clr,
    output ctl_state_e state_o
);
    ctl_state_e state;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic       oe_q;
    logic [7:0] addr_byte;

    assign addr_byte = {shreg[6:0], evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            oe_q    <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else if (evt.stop) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: if (evt.rise) begin
                    shreg   <= addr_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7)
                        state <= addr_hit(addr_byte, addr_sel) ? ST_ACK_WAIT : ST_IDLE;
                end
                ST_ACK_WAIT: if (evt.fall) begin
                    oe_q  <= 1'b1;
                    state <= ST_ADDR_ACK;
                end
                ST_ADDR_ACK, ST_RELOAD: if (evt.fall) begin
                    shreg   <= snapshot;
                    oe_q    <= ~snapshot[7];
                    bit_cnt <= '0;
                    state   <= ST_TX;
                end
                ST_TX: if (evt.fall) begin
                    if (bit_cnt == 3'd7) begin
                        oe_q  <= 1'b0;
                        state <= ST_HOST_ACK;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        oe_q    <= ~shreg[6];
                        shreg   <= {shreg[6:0], 1'b0};
                    end
                end
                ST_HOST_ACK: if (evt.rise) begin
                    state <= evt.sda ? ST_IDLE : ST_RELOAD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign por_clr = (state == ST_HOST_ACK) && evt.rise && evt.sda
                     && !evt.start && !evt.stop;
    assign sda_oe  = oe_q;
    assign state_o = state;
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       addr_sel,
    input  logic             lock_i,
    input  logic             supply_fail_i,
    input  logic [CMP_W-1:0] cmp_i
);
    localparam int AUX_W = CMP_W + 2;

    logic [1:0]       bus_s, bus_f;
    logic [AUX_W-1:0] aux_s;
    logic             scl_flt, sda_flt;
    logic             lock_s, fail_s;
    logic [CMP_W-1:0] cmp_s;
    logic             por_q, por_clr;
    bus_evt_t         evt;
    status_t          snapshot;
    ctl_state_e       state_w;

    stat_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s));

    stat_glitch_filter #(.W(2), .RST_VAL(2'b11)) u_bus_filt (
        .clk(clk), .rst(rst), .d(bus_s), .q(bus_f));

    assign scl_flt = bus_f[1];
    assign sda_flt = bus_f[0];

    stat_sync #(.W(AUX_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_aux_sync (
        .clk(clk), .rst(rst), .d({supply_fail_i, lock_i, cmp_i}), .q(aux_s));

    assign fail_s = aux_s[AUX_W-1];
    assign lock_s = aux_s[AUX_W-2];
    assign cmp_s  = aux_s[CMP_W-1:0];

    stat_bus_events u_evt (
        .clk(clk), .rst(rst), .scl(scl_flt), .sda(sda_flt), .evt(evt));

    stat_por_flag u_por (
        .clk(clk), .rst(rst), .set_i(fail_s), .clr_i(por_clr), .por_o(por_q));

    always_comb begin
        snapshot.por   = por_q;
        snapshot.lock  = lock_s;
        snapshot.pad   = '0;
        snapshot.level = therm_level(cmp_s);
    end

    stat_slave_ctrl u_ctrl (
        .clk(clk), .rst(rst), .evt(evt), .addr_sel(addr_sel),
        .snapshot(snapshot), .sda_oe(sda_oe), .por_clr(por_clr),
        .state_o(state_w));
endmodule

// File: rtl/stat_slave_chk.sv
module stat_slave_chk
    import i2c_stat_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_flt,
    input logic       sda_oe,
    input ctl_state_e state_w,
    input logic       por_q,
    input logic       fail_s
);
    // R8
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_flt);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_IDLE) |-> !sda_oe);

    // R6
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_HOST_ACK) |-> !sda_oe);

    // R7
    por_set_chk: assert property (@(posedge clk) disable iff (rst)
        fail_s |=> por_q);

    // R7
    por_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(por_q) |-> ($past(state_w) == ST_HOST_ACK && !$past(fail_s)));

    // R1
    ack_origin_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && state_w == ST_ADDR_ACK) |-> $past(state_w) == ST_ACK_WAIT);
endmodule

bind i2c_status_slave stat_slave_chk u_chk (
    .clk(clk), .rst(rst), .scl_flt(scl_flt), .sda_oe(sda_oe),
    .state_w(state_w), .por_q(por_q), .fail_s(fail_s));

// File: tb/sim_i2c_status_slave.sv
module sim_i2c_status_slave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic       lock_i = 1'b0;
    logic       supply_fail_i = 1'b0;
    logic [3:0] cmp_i = 4'b0000;
    logic       sda_oe;
    logic       sda_bus;

    int vectors = 0;
    int miscmp  = 0;
    int viol    = 0;
    logic [7:0] got [4];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_status_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .lock_i(lock_i), .supply_fail_i(supply_fail_i),
        .cmp_i(cmp_i));

    // R8 monitor: output must not change while SCL stays high
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && prev_scl && sda_oe != prev_oe) viol++;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
    endtask

    task automatic do_read(input logic [1:0] ma, input logic rw, input int n,
                           output logic acked);
        logic a;
        bus_start();
        wbyte({5'b11000, ma, rw}, a);
        acked = a;
        if (a) begin
            for (int i = 0; i < n; i++) begin
                rbyte(got[i]);
                wbit(i == n - 1);
            end
        end else begin
            rbyte(got[0]);
        end
        bus_stop();
    endtask

    function automatic logic [7:0] exp_byte(input logic por, input logic lk,
                                            input logic [3:0] c);
        return {por, lk, 3'b000, 3'(c[0] + c[1] + c[2] + c[3])};
    endfunction

    initial begin : wdog
        repeat (190000) @(posedge clk);
        miscmp++;
        vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin : main
        logic a;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 reset released", sda_oe, 0);

        // R7 flag set after reset, R5 repeated byte on master ACK
        do_read(2'b01, 1'b1, 2, a);
        chk("R1 ack", a, 1);
        chk("R7 por after reset b0", got[0], 8'h80);
        chk("R5 repeat b1", got[1], 8'h80);
        chk("R6 released after nack", sda_oe, 0);
        do_read(2'b01, 1'b1, 1, a);
        chk("R7 por cleared by nack", got[0], 8'h00);

        // R3 R4 level and lock sweep
        for (int lk = 0; lk < 2; lk++) begin
            for (int lv = 0; lv <= 4; lv++) begin
                lock_i = lk[0];
                cmp_i  = 4'((1 << lv) - 1);
                repeat (8) @(negedge clk);
                do_read(2'b01, 1'b1, 1, a);
                chk("R1 ack sweep", a, 1);
                chk("R3 R4 status byte", got[0], exp_byte(1'b0, lk[0], cmp_i));
            end
        end

        // R1 R2 address and direction sweep
        for (int sel = 0; sel < 4; sel++) begin
            addr_sel = sel[1:0];
            repeat (8) @(negedge clk);
            for (int ma = 0; ma < 4; ma++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    logic hit;
                    hit = (sel == ma) && (rw == 1);
                    do_read(ma[1:0], rw[0], 1, a);
                    chk("R1 address decode", a, int'(hit));
                    if (!hit) chk("R2 line released", got[0], 8'hFF);
                end
            end
        end
        addr_sel = 2'b10;
        repeat (8) @(negedge clk);

        // R4 R5 fresh capture per byte
        lock_i = 1'b0;
        cmp_i  = 4'b0001;
        repeat (8) @(negedge clk);
        fork
            do_read(2'b10, 1'b1, 2, a);
            begin
                repeat (500) @(negedge clk);
                cmp_i  = 4'b0111;
                lock_i = 1'b1;
            end
        join
        chk("R4 first byte old level", got[0], 8'h01);
        chk("R5 second byte recaptured", got[1], 8'h43);

        // R7 supply fail sets flag
        supply_fail_i = 1'b1;
        repeat (3) @(negedge clk);
        supply_fail_i = 1'b0;
        repeat (8) @(negedge clk);
        cmp_i = 4'b0000; lock_i = 1'b0;
        repeat (8) @(negedge clk);

        // R10 STOP after master ACK keeps flag
        bus_start();
        wbyte(8'hC5, a);
        chk("R1 ack sel10", a, 1);
        rbyte(v);
        chk("R7 supply fail sets flag", v, 8'h80);
        wbit(1'b0);
        bus_stop();
        repeat (8) @(negedge clk);
        chk("R10 idle after stop", sda_oe, 0);
        do_read(2'b10, 1'b1, 1, a);
        chk("R10 read after stop", a, 1);
        chk("R7 flag survives ack+stop", got[0], 8'h80);
        do_read(2'b10, 1'b1, 1, a);
        chk("R7 cleared by nack end", got[0], 8'h00);

        // R6 clocks after NACK are ignored
        bus_start();
        wbyte(8'hC5, a);
        rbyte(v);
        wbit(1'b1);
        rbyte(v);
        chk("R6 ignored after nack", v, 8'hFF);
        bus_stop();

        // R9 repeated START after foreign address and partial address
        bus_start();
        wbyte(8'hC3, a);
        chk("R9 foreign no ack", a, 0);
        bus_start();
        wbyte(8'hC5, a);
        chk("R9 ack after restart", a, 1);
        rbyte(v);
        wbit(1'b1);
        bus_stop();
        bus_start();
        wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b0);
        bus_start();
        wbyte(8'hC5, a);
        chk("R9 ack after partial", a, 1);
        rbyte(v);
        chk("R9 byte after partial", v, 8'h00);
        wbit(1'b1);
        bus_stop();

        chk("R8 output stable while SCL high", viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule